// File: doc/BRIEF.md
# Configurable Output Logic Cell for a Sum-of-Products Programmable Device

This block is a single output logic cell of a small programmable logic device. It takes the results of eight product terms from the AND array and ORs them into a sum term. It can invert that sum, and it can store it in a flip-flop. It decides when the cell's pad is driven, and it picks the signal that goes back into the array as feedback. The device drives the pad through a tri-state model, made of a data signal and an enable signal. The pad's own value comes back into the cell as an input.

Two static configuration fields set the behaviour. A two-bit device mode is shared by all cells: registered, complex or simple. A two-bit cell function is set per cell: registered output, combinatorial I/O, combinatorial output, or dedicated input. A polarity bit selects active-high or active-low output. The mode and the function together decide three things: whether one product term is taken out of the sum to act as the output enable, where the feedback comes from, and whether the flip-flop is clocked. The cell's position in the row of cells is a parameter. The two outermost cells and the two centre cells behave differently in some modes.

The flip-flop has three ways to change. Power-up reset clears it asynchronously. A test preload strobe writes any chosen value into it, with no clock edge needed. The clock edge loads the sum term, but only when the cell is used as a registered output in registered mode.

Top module: `pld_macrocell`

## Requirements
- R1: While `rst_n` is low, the flip-flop is cleared to 0. A registered-output cell in registered mode therefore shows `pad_out` = 1 when `out_inv` = 1, and `pad_out` = 0 when `out_inv` = 0.
- R2: Registered mode (`dev_mode` = 00) with registered-output function (`cell_fn` = 00):
  - On each rising clock edge the flip-flop loads the OR of all eight product terms.
  - `pad_out` is the flip-flop value XOR `out_inv`.
  - `pad_oe` is the inverse of `oe_pin_n`.
  - `fb` is the flip-flop value.
- R3: Registered mode with combinatorial I/O function (`cell_fn` = 01):
  - `pad_out` is the OR of `pt[7:1]`, XOR `out_inv`.
  - `pad_oe` equals `pt[0]`.
  - `fb` is the resolved pad value. This is `pad_out` when the pad is driven and `pad_in` when it is not.
- R4: Complex mode (`dev_mode` = 01), for a cell that is neither a dedicated input nor an outer cell:
  - `pad_out` is the OR of `pt[7:1]`, XOR `out_inv`.
  - `pad_oe` equals `pt[0]`, for function 00 or 01.
  - `fb` is the resolved pad value.
  - The registered-output function acts as combinatorial I/O in this mode.
- R5: In complex mode, the outermost cells (index 0 and NUM_CELLS-1) drive `fb` = 0 for every function.
- R6: Simple mode (`dev_mode` = 10, and 11 is treated the same way), for a non-centre cell whose function is not dedicated input:
  - `pad_out` is the OR of all eight terms, XOR `out_inv`.
  - `pad_oe` is 1.
  - `fb` equals `pad_out`.
- R7: In simple mode, the two centre cells (index NUM_CELLS/2-1 and NUM_CELLS/2) ignore `cell_fn`. They always show `pad_oe` = 1, `pad_out` = OR of all eight terms XOR `out_inv`, and `fb` = 0.
- R8: A dedicated-input cell (`cell_fn` = 11) shows `pad_oe` = 0 and `pad_out` = 0, and `fb` = `pad_in`. This holds except for an outer cell in complex mode, where R5 applies, and a centre cell in simple mode, where R7 applies.
- R9: The combinatorial-output function (`cell_fn` = 10) in registered or complex mode:
  - `pad_oe` is always 1.
  - `pad_out` is the OR of `pt[7:1]`, XOR `out_inv`.
  - `fb` equals `pad_out`, except for an outer cell in complex mode, where R5 applies.
- R10: A rising edge on `pl_strobe` writes `pl_val` into the flip-flop at once, in any mode. While `pl_strobe` stays high, clock edges leave that value in place.
- R11: Outside the combination of registered mode and registered-output function, the flip-flop holds its value across clock edges. The held value becomes visible again when the cell is switched back to a registered output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global register clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| pt | input | NUM_PT | Product-term results from the AND array |
| oe_pin_n | input | 1 | Shared output-enable pin, active low |
| pl_strobe | input | 1 | Preload strobe; its rising edge writes `pl_val` into the flip-flop |
| pl_val | input | 1 | Preload value |
| dev_mode | input | 2 | Device mode: 00 registered, 01 complex, 10/11 simple |
| cell_fn | input | 2 | Cell function: 00 registered out, 01 comb I/O, 10 comb out, 11 input |
| out_inv | input | 1 | 1 selects active-low output |
| pad_in | input | 1 | Value present on the pad |
| pad_out | output | 1 | Data driven toward the pad |
| pad_oe | output | 1 | Pad driver enable |
| fb | output | 1 | Feedback into the AND array |

## Verification
The hardest state to observe is the flip-flop while the cell is not a registered output. Its value reaches no port, so the bench first preloads it, then runs many clock edges in complex mode with active product terms. It then switches the cell back to a registered output and checks the pad before any further edge. A second hard case is a preload strobe held high across a clock edge while the array requests the opposite value. The bench also places three copies of the cell at an outer, an inner and a centre position, so that all the position rules are exercised in every mode.

// File: rtl/pld_mc_pkg.sv
package pld_mc_pkg;

    typedef enum logic [1:0] {
        DEV_REG    = 2'b00,
        DEV_CPLX   = 2'b01,
        DEV_SIMPLE = 2'b10,
        DEV_ALT    = 2'b11
    } dev_mode_e;

    typedef enum logic [1:0] {
        CELL_REG = 2'b00,
        CELL_IO  = 2'b01,
        CELL_OUT = 2'b10,
        CELL_IN  = 2'b11
    } cell_fn_e;

    typedef enum logic [1:0] {
        OE_NONE,
        OE_ALWAYS,
        OE_PIN,
        OE_TERM
    } oe_src_e;

    typedef enum logic [1:0] {
        FB_NONE,
        FB_REG,
        FB_PAD
    } fb_src_e;

    typedef struct packed {
        logic    use_reg;   // pad data taken from the flip-flop
        logic    clk_en;    // flip-flop loads the sum on the clock
        logic    term_oe;   // first product term is removed from the sum
        oe_src_e oe_src;
        fb_src_e fb_src;
    } cell_ctl_t;

    typedef struct packed {
        logic q;
    } cell_state_t;

endpackage

// File: rtl/pld_mc_route.sv
module pld_mc_route
    import pld_mc_pkg::*;
#(
    parameter int NUM_CELLS = 8,
    parameter int CELL_IDX  = 2
) (
    input  logic [1:0] dev_mode,
    input  logic [1:0] cell_fn,
    output cell_ctl_t  ctl
);
    localparam bit IS_OUTER  = (CELL_IDX == 0) || (CELL_IDX == NUM_CELLS - 1);
    localparam bit IS_CENTRE = (CELL_IDX == NUM_CELLS / 2 - 1) || (CELL_IDX == NUM_CELLS / 2);

    dev_mode_e mode_eff;
    cell_fn_e  fn;

    always_comb begin
        fn       = cell_fn_e'(cell_fn);
        mode_eff = (dev_mode == DEV_ALT) ? DEV_SIMPLE : dev_mode_e'(dev_mode);

        ctl         = '0;
        ctl.oe_src  = OE_NONE;
        ctl.fb_src  = FB_NONE;

        case (mode_eff)
            DEV_REG: begin
                case (fn)
                    CELL_REG: begin
                        ctl.use_reg = 1'b1;
                        ctl.clk_en  = 1'b1;
                        ctl.oe_src  = OE_PIN;
                        ctl.fb_src  = FB_REG;
                    end
                    CELL_IO: begin
                        ctl.term_oe = 1'b1;
                        ctl.oe_src  = OE_TERM;
                        ctl.fb_src  = FB_PAD;
                    end
                    CELL_OUT: begin
                        ctl.term_oe = 1'b1;
                        ctl.oe_src  = OE_ALWAYS;
                        ctl.fb_src  = FB_PAD;
                    end
                    default: begin
                        ctl.term_oe = 1'b1;
                        ctl.oe_src  = OE_NONE;
                        ctl.fb_src  = FB_PAD;
                    end
                endcase
            end
            DEV_CPLX: begin
                ctl.term_oe = 1'b1;
                ctl.fb_src  = IS_OUTER ? FB_NONE : FB_PAD;
                case (fn)
                    CELL_IN:  ctl.oe_src = OE_NONE;
                    CELL_OUT: ctl.oe_src = OE_ALWAYS;
                    default:  ctl.oe_src = OE_TERM;
                endcase
            end
            default: begin
                if (IS_CENTRE) begin
                    ctl.oe_src = OE_ALWAYS;
                    ctl.fb_src = FB_NONE;
                end else if (fn == CELL_IN) begin
                    ctl.oe_src = OE_NONE;
                    ctl.fb_src = FB_PAD;
                end else begin
                    ctl.oe_src = OE_ALWAYS;
                    ctl.fb_src = FB_PAD;
                end
            end
        endcase
    end

endmodule

// File: rtl/pld_mc_sum.sv
module pld_mc_sum #(
    parameter int NUM_PT = 8
) (
    input  logic [NUM_PT-1:0] pt,
    input  logic              skip_first,
    output logic              sum
);
    logic [NUM_PT-1:0] kept;

    for (genvar i = 0; i < NUM_PT; i++) begin : g_term
        if (i == 0) begin : g_oe_slot
            assign kept[i] = pt[i] & ~skip_first;
        end else begin : g_plain
            assign kept[i] = pt[i];
        end
    end

    assign sum = |kept;

endmodule

// File: rtl/pld_mc_pad.sv
module pld_mc_pad
    import pld_mc_pkg::*;
(
    input  cell_ctl_t ctl,
    input  logic      sum,
    input  logic      q,
    input  logic      out_inv,
    input  logic      oe_pin_n,
    input  logic      enable_term,
    input  logic      pad_in,
    output logic      pad_out,
    output logic      pad_oe,
    output logic      fb
);
    logic drive_val;

    always_comb begin
        drive_val = (ctl.use_reg ? q : sum) ^ out_inv;

        case (ctl.oe_src)
            OE_ALWAYS: begin pad_oe = 1'b1;         pad_out = drive_val; end
            OE_PIN:    begin pad_oe = ~oe_pin_n;    pad_out = drive_val; end
            OE_TERM:   begin pad_oe = enable_term;  pad_out = drive_val; end
            default:   begin pad_oe = 1'b0;         pad_out = 1'b0;      end
        endcase

        case (ctl.fb_src)
            FB_REG:  fb = q;
            FB_PAD:  fb = pad_oe ? pad_out : pad_in;
            default: fb = 1'b0;
        endcase
    end

endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
    import pld_mc_pkg::*;
#(
    parameter int NUM_PT    = 8,
    parameter int NUM_CELLS = 8,
    parameter int CELL_IDX  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_PT-1:0] pt,
    input  logic              oe_pin_n,
    input  logic              pl_strobe,
    input  logic              pl_val,
    input  logic [1:0]        dev_mode,
    input  logic [1:0]        cell_fn,
    input  logic              out_inv,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              fb
);
    cell_ctl_t   ctl;
    logic        sum;
    cell_state_t st_d, st_q;

    pld_mc_route #(
        .NUM_CELLS (NUM_CELLS),
        .CELL_IDX  (CELL_IDX)
    ) u_route (
        .dev_mode (dev_mode),
        .cell_fn  (cell_fn),
        .ctl      (ctl)
    );

    pld_mc_sum #(
        .NUM_PT (NUM_PT)
    ) u_sum (
        .pt         (pt),
        .skip_first (ctl.term_oe),
        .sum        (sum)
    );

    always_comb begin
        st_d = st_q;
        if (ctl.clk_en) begin
            st_d.q = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n or posedge pl_strobe) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (pl_strobe) begin
            st_q.q <= pl_val;
        end else begin
            st_q <= st_d;
        end
    end

    pld_mc_pad u_pad (
        .ctl         (ctl),
        .sum         (sum),
        .q           (st_q.q),
        .out_inv     (out_inv),
        .oe_pin_n    (oe_pin_n),
        .enable_term (pt[0]),
        .pad_in      (pad_in),
        .pad_out     (pad_out),
        .pad_oe      (pad_oe),
        .fb          (fb)
    );

endmodule

// File: rtl/pld_mc_check.sv
module pld_mc_check #(
    parameter int NUM_PT    = 8,
    parameter int NUM_CELLS = 8,
    parameter int CELL_IDX  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_PT-1:0] pt,
    input logic              oe_pin_n,
    input logic [1:0]        dev_mode,
    input logic [1:0]        cell_fn,
    input logic              pad_oe,
    input logic              fb
);
    localparam bit OUTER  = (CELL_IDX == 0) || (CELL_IDX == NUM_CELLS - 1);
    localparam bit CENTRE = (CELL_IDX == NUM_CELLS / 2 - 1) || (CELL_IDX == NUM_CELLS / 2);

    logic simple_m;
    assign simple_m = dev_mode[1];

    AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_fn == 2'b11 && !(simple_m && CENTRE)) |-> !pad_oe); // R8

    AST_SIMPLE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (simple_m && cell_fn != 2'b11) |-> pad_oe); // R6

    AST_CENTRE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (simple_m && CENTRE) |-> (pad_oe && !fb)); // R7

    AST_OUTER_NO_FB: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode == 2'b01 && OUTER) |-> !fb); // R5

    AST_PIN_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode == 2'b00 && cell_fn == 2'b00) |-> (pad_oe == !oe_pin_n)); // R2

    AST_TERM_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_mode == 2'b00 && cell_fn == 2'b01) |-> (pad_oe == pt[0])); // R3

endmodule

bind pld_macrocell pld_mc_check #(
    .NUM_PT    (NUM_PT),
    .NUM_CELLS (NUM_CELLS),
    .CELL_IDX  (CELL_IDX)
) u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .pt       (pt),
    .oe_pin_n (oe_pin_n),
    .dev_mode (dev_mode),
    .cell_fn  (cell_fn),
    .pad_oe   (pad_oe),
    .fb       (fb)
);

// File: tb/pld_macrocell_test.sv
module pld_macrocell_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pt = '0;
    logic       oe_pin_n = 1'b0;
    logic       pl_strobe = 1'b0;
    logic       pl_val = 1'b0;
    logic [1:0] dev_mode = 2'b00;
    logic [1:0] cell_fn = 2'b00;
    logic       out_inv = 1'b1;
    logic       pad_in = 1'b0;

    logic [2:0] o_in, o_edge, o_mid;

    int    n_cmp = 0;
    int    n_bad = 0;
    logic  q_m = 1'b0;
    string tag_force = "";

    always #4 clk = ~clk;

    pld_macrocell #(.CELL_IDX(2)) uut (
        .clk(clk), .rst_n(rst_n), .pt(pt), .oe_pin_n(oe_pin_n),
        .pl_strobe(pl_strobe), .pl_val(pl_val), .dev_mode(dev_mode),
        .cell_fn(cell_fn), .out_inv(out_inv), .pad_in(pad_in),
        .pad_out(o_in[2]), .pad_oe(o_in[1]), .fb(o_in[0]));

    pld_macrocell #(.CELL_IDX(0)) uut_edge (
        .clk(clk), .rst_n(rst_n), .pt(pt), .oe_pin_n(oe_pin_n),
        .pl_strobe(pl_strobe), .pl_val(pl_val), .dev_mode(dev_mode),
        .cell_fn(cell_fn), .out_inv(out_inv), .pad_in(pad_in),
        .pad_out(o_edge[2]), .pad_oe(o_edge[1]), .fb(o_edge[0]));

    pld_macrocell #(.CELL_IDX(3)) uut_mid (
        .clk(clk), .rst_n(rst_n), .pt(pt), .oe_pin_n(oe_pin_n),
        .pl_strobe(pl_strobe), .pl_val(pl_val), .dev_mode(dev_mode),
        .cell_fn(cell_fn), .out_inv(out_inv), .pad_in(pad_in),
        .pad_out(o_mid[2]), .pad_oe(o_mid[1]), .fb(o_mid[0]));

    // Expected {pad_out, pad_oe, fb} for a cell at position pos
    function automatic logic [2:0] expect_cell(int pos);
        logic s8, s7, o, e, f;
        bit outer, centre;
        int md, fn;
        md = dev_mode; fn = cell_fn;
        s8 = |pt; s7 = |pt[7:1];
        outer  = (pos == 0) || (pos == 7);
        centre = (pos == 3) || (pos == 4);
        if (md >= 2) begin
            if (centre)        begin o = s8 ^ out_inv; e = 1; f = 0; end
            else if (fn == 3)  begin o = 0; e = 0; f = pad_in; end
            else               begin o = s8 ^ out_inv; e = 1; f = o; end
        end else if (md == 1) begin
            if (fn == 3) begin o = 0; e = 0; f = outer ? 1'b0 : pad_in; end
            else begin
                o = s7 ^ out_inv;
                e = (fn == 2) ? 1'b1 : pt[0];
                f = outer ? 1'b0 : (e ? o : pad_in);
            end
        end else begin
            case (fn)
                0:       begin o = q_m ^ out_inv; e = !oe_pin_n; f = q_m; end
                1:       begin o = s7 ^ out_inv; e = pt[0]; f = e ? o : pad_in; end
                2:       begin o = s7 ^ out_inv; e = 1; f = o; end
                default: begin o = 0; e = 0; f = pad_in; end
            endcase
        end
        return {o, e, f};
    endfunction

    function automatic string req_of(int pos);
        int md, fn;
        bit outer, centre;
        md = dev_mode; fn = cell_fn;
        outer  = (pos == 0) || (pos == 7);
        centre = (pos == 3) || (pos == 4);
        if (tag_force != "") return tag_force;
        if (md >= 2) return centre ? "R7" : (fn == 3 ? "R8" : "R6");
        if (md == 1) return outer ? "R5" : (fn == 3 ? "R8" : (fn == 2 ? "R9" : "R4"));
        case (fn)
            0: return "R2";
            1: return "R3";
            2: return "R9";
            default: return "R8";
        endcase
    endfunction

    task automatic cmp_one(int pos, logic [2:0] got);
        logic [2:0] want;
        want = expect_cell(pos);
        n_cmp++;
        if (got !== want) begin
            n_bad++;
            $display("FAIL %s cell %0d mode=%0d fn=%0d: got %b expected %b",
                     req_of(pos), pos, dev_mode, cell_fn, got, want);
        end
    endtask

    task automatic check_all();
        cmp_one(2, o_in);
        cmp_one(0, o_edge);
        cmp_one(3, o_mid);
    endtask

    // one clock: model update at the edge, compare at the falling edge
    task automatic cycle();
        @(posedge clk);
        if (!rst_n)                              q_m = 1'b0;
        else if (pl_strobe)                      q_m = pl_val;
        else if (dev_mode == 0 && cell_fn == 0)  q_m = |pt;
        @(negedge clk);
        check_all();
    endtask

    task automatic preload(logic v);
        pl_val = v;
        pl_strobe = 1'b1;
        #1;
        pl_strobe = 1'b0;
        q_m = v;
        #1;
        check_all();
    endtask

    task automatic rand_data();
        pt       = 8'($urandom);
        oe_pin_n = 1'($urandom);
        out_inv  = 1'($urandom);
        pad_in   = 1'($urandom);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state in both polarities
        tag_force = "R1";
        pt = 8'hFF;
        cycle();
        out_inv = 1'b0;
        #1 check_all();
        out_inv = 1'b1;
        cycle();
        rst_n = 1'b1;
        tag_force = "";

        // every mode and function with random data
        for (int md = 0; md < 4; md++) begin
            for (int fn = 0; fn < 4; fn++) begin
                dev_mode = 2'(md);
                cell_fn  = 2'(fn);
                for (int k = 0; k < 40; k++) begin
                    rand_data();
                    cycle();
                end
            end
        end

        // R10: preload both values, then hold strobe across an edge
        tag_force = "R10";
        dev_mode = 2'b00; cell_fn = 2'b00; oe_pin_n = 1'b0; out_inv = 1'b0;
        pt = 8'h00;
        preload(1'b1);
        preload(1'b0);
        pt = 8'h80;
        pl_val = 1'b0;
        pl_strobe = 1'b1;
        cycle();
        pl_strobe = 1'b0;
        #1 check_all();
        tag_force = "";

        // R11: value held while the cell is combinatorial
        for (int v = 0; v < 2; v++) begin
            tag_force = "R11";
            dev_mode = 2'b00; cell_fn = 2'b00; pt = 8'h00;
            preload(v[0]);
            dev_mode = 2'b01;
            tag_force = "";
            for (int k = 0; k < 20; k++) begin
                rand_data();
                pt[1] = ~v[0];
                cycle();
            end
            dev_mode = 2'b10;
            for (int k = 0; k < 10; k++) begin
                rand_data();
                cycle();
            end
            tag_force = "R11";
            dev_mode = 2'b00; cell_fn = 2'b00;
            #1 check_all();
            tag_force = "";
            cell_fn = 2'b01;
            cycle();
        end

        // random configuration and data with occasional preload
        for (int k = 0; k < 3000; k++) begin
            dev_mode = 2'($urandom);
            cell_fn  = 2'($urandom);
            rand_data();
            if ($urandom_range(0, 15) == 0) preload(1'($urandom));
            cycle();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule